// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This block runs the self-tests of a storage encryption engine without any operator input. When reset is released, it first walks through the firmware image integrity checks: the main image, then the bootloader, then the configuration data. Only after all three pass does it enable the host link. It then runs the cryptographic known-answer tests one at a time in a fixed order. Each check is carried out by an external engine through a start pulse and a done/pass reply. A per-step timer turns a silent engine into a failure.

Data output is released only when every test has passed, no test is running and no zeroization is in progress. An integrity failure keeps the host link disabled, so the status port reads as zero. A known-answer failure keeps the link up and reports the failing test in status bits. Every error state is held until reset. While the block is ready, a control input can start the known-answer tests again. A failure in such a run enters an on-demand error state of its own.

Top module: `pst_sequencer`

## Requirements
- R1: After reset the integrity checks start in the order main image (integ_start bit 0), bootloader (bit 1), configuration data (bit 2). Each start is a single-cycle pulse. integ_wide is high with the start of the two 32-bit CRC checks (bits 1 and 2) and low with the start of the 16-bit CRC check (bit 0).
- R2: Known-answer tests start only after every integrity check has passed. They run one at a time, each start being a pulse, in the order ans_start bit 0 XTS-AES encrypt, bit 1 XTS-AES decrypt, bit 2 AES key unwrap, bit 3 HMAC-SHA-256 verify.
- R3: link_en rises once all integrity checks have passed and then stays high. If an integrity check fails, link_en stays low until reset and no known-answer test starts.
- R4: If a known-answer test fails during the power-up run, the later tests do not start. Status word 0 bit 1 is set, and status word 1 bit k is set for failing test k.
- R5: A check whose done does not arrive within TMO_CYCLES cycles of its start counts as a failure.
- R6: out_en is high only when all tests have passed, no run is active and zeroize_req is low. It falls one cycle after zeroize_req rises and returns one cycle after it falls.
- R7: ondemand_req is accepted only in the ready state. It reruns the four known-answer tests in the R2 order while out_en is low and status word 0 bit 3 (busy) is set. A pass returns to ready. A fail sets status word 0 bit 2 and the failing test's bit in word 1.
- R8: Error states persist until reset, and ondemand_req has no effect in them.
- R9: rd_data shows the status word selected by rd_addr one cycle later. Word 0 holds bit 0 ready, bit 1 power-up test error, bit 2 on-demand test error and bit 3 busy. Word 1 holds the per-test failure bits. rd_data reads zero while link_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ondemand_req | input | 1 | Request to rerun the known-answer tests |
| zeroize_req | input | 1 | Zeroization in progress; blocks data output |
| integ_start | output | N_INTEG | One-hot start pulse per integrity check |
| integ_wide | output | 1 | High when the started check uses a 32-bit CRC |
| integ_done | input | 1 | Integrity engine finished |
| integ_pass | input | 1 | Integrity result, valid with integ_done |
| ans_start | output | N_ANS | One-hot start pulse per known-answer test |
| ans_done | input | 1 | Known-answer engine finished |
| ans_pass | input | 1 | Known-answer result, valid with ans_done |
| link_en | output | 1 | Host link enable |
| out_en | output | 1 | Data output permitted |
| rd_addr | input | 1 | Status word select |
| rd_data | output | STAT_W | Status word, one cycle after rd_addr |

## Verification
The bench targets a failure at every position of the sequence. A wrong design would either keep starting later tests, which shows as extra entries in the start log, or raise the link after a bad image. Engines that hang probe the timer: a design without a working timeout would sit in the running state forever, never report an error and keep out_en low with no status. On-demand requests are sent during the power-up run, in the ready state and in error states. A design that accepted them outside ready would restart tests or clear a sticky error. Zeroization in the ready state checks the one-cycle fall and recovery of out_en.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [2:0] {
    ST_INTEG    = 3'd0,
    ST_ANS      = 3'd1,
    ST_READY    = 3'd2,
    ST_ERR_LINK = 3'd3,
    ST_ERR_ANS  = 3'd4,
    ST_ERR_OND  = 3'd5
  } pst_state_e;

  // bit positions in status word 0
  localparam int STB_READY  = 0;
  localparam int STB_PUERR  = 1;
  localparam int STB_ONDERR = 2;
  localparam int STB_BUSY   = 3;
  localparam int STB_COUNT  = 4;
endpackage

// File: rtl/pst_pulse_dec.sv
module pst_pulse_dec #(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     pulse
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign hit[g] = (sel == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= '0;
    else     pulse <= fire ? hit : '0;
  end

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> !(|pulse));
endmodule

// File: rtl/pst_step_timer.sv
module pst_step_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // R5
  tmo_end_chk: assert property (@(posedge clk) disable iff (rst)
    expired |=> !run);
endmodule

// File: rtl/pst_status.sv
module pst_status #(
  parameter int N_ANS  = 4,
  parameter int SEL_W  = 2,
  parameter int STAT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      set_fail,
  input  logic [SEL_W-1:0]          fail_idx,
  input  logic [pst_pkg::STB_COUNT-1:0] flags,
  input  logic                      visible,
  input  logic                      rd_addr,
  output logic [STAT_W-1:0]         rd_data
);
  logic [N_ANS-1:0]  fail_q;
  logic [STAT_W-1:0] word0, word1;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= '0;
    end else if (set_fail) begin
      for (int i = 0; i < N_ANS; i++)
        if (fail_idx == SEL_W'(i)) fail_q[i] <= 1'b1;
    end
  end

  assign word0 = STAT_W'(flags);
  assign word1 = STAT_W'(fail_q);

  always_ff @(posedge clk) begin
    if (rst || !visible) rd_data <= '0;
    else                 rd_data <= rd_addr ? word1 : word0;
  end

  // R9
  hidden_read_chk: assert property (@(posedge clk) disable iff (rst)
    (|rd_data) |-> $past(visible));
  // R4
  fail_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (|fail_q) |=> (|fail_q));
endmodule

// File: rtl/pst_sequencer.sv
module pst_sequencer #(
  parameter int N_INTEG    = 3,
  parameter int N_ANS      = 4,
  parameter logic [N_INTEG-1:0] INTEG_WIDE_MASK = 3'b110,
  parameter int TMO_CYCLES = 4096,
  parameter int STAT_W     = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ondemand_req,
  input  logic               zeroize_req,
  output logic [N_INTEG-1:0] integ_start,
  output logic               integ_wide,
  input  logic               integ_done,
  input  logic               integ_pass,
  output logic [N_ANS-1:0]   ans_start,
  input  logic               ans_done,
  input  logic               ans_pass,
  output logic               link_en,
  output logic               out_en,
  input  logic               rd_addr,
  output logic [STAT_W-1:0]  rd_data
);
  import pst_pkg::*;

  localparam int NMAX  = (N_INTEG > N_ANS) ? N_INTEG : N_ANS;
  localparam int SEL_W = (NMAX > 1) ? $clog2(NMAX) : 1;
  localparam logic [SEL_W-1:0] LAST_INTEG = SEL_W'(N_INTEG - 1);
  localparam logic [SEL_W-1:0] LAST_ANS   = SEL_W'(N_ANS - 1);

  pst_state_e       state;
  logic [SEL_W-1:0] idx;
  logic             waiting, ond_q, link_q, out_q, wide_q;

  logic fire_integ, fire_ans, run_tmo, expired;
  logic step_done, step_pass, step_ok, step_fail, last_step;
  logic in_test, set_fail;
  logic [STB_COUNT-1:0] flags;

  assign in_test    = (state == ST_INTEG) || (state == ST_ANS);
  assign fire_integ = (state == ST_INTEG) && !waiting;
  assign fire_ans   = (state == ST_ANS)   && !waiting;
  assign run_tmo    = in_test && waiting;
  assign step_done  = (state == ST_INTEG) ? integ_done : ans_done;
  assign step_pass  = (state == ST_INTEG) ? integ_pass : ans_pass;
  assign step_ok    = run_tmo && step_done && step_pass;
  assign step_fail  = run_tmo && ((step_done && !step_pass) || (!step_done && expired));
  assign last_step  = (state == ST_INTEG) ? (idx == LAST_INTEG) : (idx == LAST_ANS);
  assign set_fail   = step_fail && (state == ST_ANS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_INTEG;
      idx     <= '0;
      waiting <= 1'b0;
      ond_q   <= 1'b0;
      link_q  <= 1'b0;
      out_q   <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      out_q  <= (state == ST_READY) && !zeroize_req;
      wide_q <= fire_integ ? INTEG_WIDE_MASK[idx] : 1'b0;
      unique case (state)
        ST_INTEG, ST_ANS: begin
          if (!waiting) begin
            waiting <= 1'b1;
          end else if (step_fail) begin
            waiting <= 1'b0;
            if (state == ST_INTEG) state <= ST_ERR_LINK;
            else state <= ond_q ? ST_ERR_OND : ST_ERR_ANS;
          end else if (step_ok) begin
            waiting <= 1'b0;
            if (last_step) begin
              idx <= '0;
              if (state == ST_INTEG) begin
                state  <= ST_ANS;
                link_q <= 1'b1;
              end else begin
                state <= ST_READY;
                ond_q <= 1'b0;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_READY: begin
          if (ondemand_req) begin
            state   <= ST_ANS;
            ond_q   <= 1'b1;
            idx     <= '0;
            waiting <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  assign link_en    = link_q;
  assign out_en     = out_q;
  assign integ_wide = wide_q;

  assign flags[STB_READY]  = (state == ST_READY);
  assign flags[STB_PUERR]  = (state == ST_ERR_ANS);
  assign flags[STB_ONDERR] = (state == ST_ERR_OND);
  assign flags[STB_BUSY]   = (state == ST_ANS);

  pst_pulse_dec #(.N(N_INTEG), .SEL_W(SEL_W)) u_integ_dec (
    .clk(clk), .rst(rst), .fire(fire_integ), .sel(idx), .pulse(integ_start)
  );

  pst_pulse_dec #(.N(N_ANS), .SEL_W(SEL_W)) u_ans_dec (
    .clk(clk), .rst(rst), .fire(fire_ans), .sel(idx), .pulse(ans_start)
  );

  pst_step_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(run_tmo), .expired(expired)
  );

  pst_status #(.N_ANS(N_ANS), .SEL_W(SEL_W), .STAT_W(STAT_W)) u_status (
    .clk(clk), .rst(rst), .set_fail(set_fail), .fail_idx(idx), .flags(flags),
    .visible(link_q), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R1
  start_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({integ_start, ans_start}));
  // R3
  link_hold_chk: assert property (@(posedge clk) disable iff (rst)
    link_en |=> link_en);
  // R3
  link_err_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR_LINK) |-> !link_en);
  // R2
  ans_after_link_chk: assert property (@(posedge clk) disable iff (rst)
    (|ans_start) |-> link_en);
  // R6
  out_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |-> ($past(!zeroize_req) && link_en));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERR_LINK || state == ST_ERR_ANS || state == ST_ERR_OND)
      |=> (state == $past(state)));
endmodule

// File: tb/sim_pst_sequencer.sv
module sim_pst_sequencer;
  localparam int NI = 3;
  localparam int NA = 4;
  localparam int TMO = 40;
  localparam int SETTLE = 320;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          ondemand_req = 1'b0, zeroize_req = 1'b0;
  logic [NI-1:0] integ_start;
  logic          integ_wide;
  logic          integ_done, integ_pass;
  logic [NA-1:0] ans_start;
  logic          ans_done, ans_pass;
  logic          link_en, out_en;
  logic          rd_addr = 1'b0;
  logic [7:0]    rd_data;

  pst_sequencer #(.N_INTEG(NI), .N_ANS(NA), .INTEG_WIDE_MASK(3'b110),
                  .TMO_CYCLES(TMO), .STAT_W(8)) u0 (
    .clk(clk), .rst(rst), .ondemand_req(ondemand_req), .zeroize_req(zeroize_req),
    .integ_start(integ_start), .integ_wide(integ_wide), .integ_done(integ_done),
    .integ_pass(integ_pass), .ans_start(ans_start), .ans_done(ans_done),
    .ans_pass(ans_pass), .link_en(link_en), .out_en(out_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  bit ipass[NI], ihang[NI], apass[NA], ahang[NA];
  int log_id[64];
  bit log_w[64];
  int log_n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // integrity engine model
  initial begin
    int k;
    integ_done = 0; integ_pass = 0;
    forever begin
      @(negedge clk);
      if (!rst && (|integ_start)) begin
        k = 0;
        for (int i = 0; i < NI; i++) if (integ_start[i]) k = i;
        if (log_n < 64) begin log_id[log_n] = k; log_w[log_n] = integ_wide; log_n++; end
        if (!ihang[k]) begin
          repeat ($urandom_range(1, TMO/2)) @(negedge clk);
          integ_done = 1; integ_pass = ipass[k];
          @(negedge clk);
          integ_done = 0; integ_pass = 0;
        end
      end
    end
  end

  // known-answer engine model
  initial begin
    int k;
    ans_done = 0; ans_pass = 0;
    forever begin
      @(negedge clk);
      if (!rst && (|ans_start)) begin
        k = 0;
        for (int i = 0; i < NA; i++) if (ans_start[i]) k = i;
        if (log_n < 64) begin log_id[log_n] = 8 + k; log_w[log_n] = 0; log_n++; end
        if (!ahang[k]) begin
          repeat ($urandom_range(1, TMO/2)) @(negedge clk);
          ans_done = 1; ans_pass = apass[k];
          @(negedge clk);
          ans_done = 0; ans_pass = 0;
        end
      end
    end
  end

  function automatic int first_integ_fail();
    for (int i = 0; i < NI; i++) if (!ipass[i] || ihang[i]) return i;
    return -1;
  endfunction

  function automatic int first_ans_fail();
    for (int i = 0; i < NA; i++) if (!apass[i] || ahang[i]) return i;
    return -1;
  endfunction

  function automatic int exp_id(input int j);
    return (j < NI) ? j : 8 + (j - NI);
  endfunction

  // kind: 0 all pass, 1 integ fail, 2 integ hang, 3 ans fail, 4 ans hang
  task automatic set_cfg(input int kind, input int where);
    for (int i = 0; i < NI; i++) begin ipass[i] = 1; ihang[i] = 0; end
    for (int i = 0; i < NA; i++) begin apass[i] = 1; ahang[i] = 0; end
    case (kind)
      1: ipass[where % NI] = 0;
      2: ihang[where % NI] = 1;
      3: apass[where % NA] = 0;
      4: ahang[where % NA] = 1;
      default: ;
    endcase
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic pulse_req();
    ondemand_req = 1;
    @(negedge clk);
    ondemand_req = 0;
  endtask

  task automatic run_powerup(input bit check_reset, input bit poke_req);
    logic [7:0] w0, w1;
    int fi, fa, elen;
    rst = 1;
    log_n = 0;
    repeat (4) @(negedge clk);
    if (check_reset) begin
      chk(link_en == 0, "R3 reset link", link_en, 0);
      chk(out_en == 0, "R6 reset out_en", out_en, 0);
      chk(integ_start == 0 && ans_start == 0, "R1 reset starts", {integ_start, ans_start}, 0);
      chk(rd_data == 0, "R9 reset rd_data", rd_data, 0);
    end
    rst = 0;
    if (poke_req) begin
      repeat (3) @(negedge clk);
      pulse_req();
    end
    repeat (SETTLE) @(negedge clk);
    fi = first_integ_fail();
    fa = first_ans_fail();
    if (fi >= 0) elen = fi + 1;
    else if (fa >= 0) elen = NI + fa + 1;
    else elen = NI + NA;
    chk(log_n == elen, "R2 start count", log_n, elen);
    for (int j = 0; j < log_n && j < elen; j++) begin
      chk(log_id[j] == exp_id(j), "R1 R2 start order", log_id[j], exp_id(j));
      if (j < NI) chk(log_w[j] == (j != 0), "R1 crc width", log_w[j], (j != 0));
    end
    rd(0, w0);
    rd(1, w1);
    if (fi >= 0) begin
      chk(link_en == 0, "R3 link after integ fail", link_en, 0);
      chk(out_en == 0, "R6 out after integ fail", out_en, 0);
      chk(w0 == 0 && w1 == 0, "R9 hidden status", {w0, w1}, 0);
    end else if (fa >= 0) begin
      chk(link_en == 1, "R3 link up", link_en, 1);
      chk(out_en == 0, "R6 out after test fail", out_en, 0);
      chk(w0 == 8'h02, "R4 word0", w0, 2);
      chk(w1 == 8'(1 << fa), "R4 R5 word1", w1, 1 << fa);
    end else begin
      chk(link_en == 1, "R3 link up", link_en, 1);
      chk(out_en == 1, "R6 out ready", out_en, 1);
      chk(w0 == 8'h01, "R9 word0 ready", w0, 1);
      chk(w1 == 0, "R9 word1 clean", w1, 0);
    end
  endtask

  task automatic check_sticky();
    logic [7:0] a0, b0;
    int n0;
    logic l0;
    rd(0, a0);
    n0 = log_n; l0 = link_en;
    pulse_req();
    repeat (100) @(negedge clk);
    rd(0, b0);
    chk(log_n == n0, "R8 no restart in error", log_n, n0);
    chk(b0 == a0, "R8 status held", b0, a0);
    chk(link_en == l0 && out_en == 0, "R8 outputs held", {link_en, out_en}, {l0, 1'b0});
  endtask

  initial begin
    logic [7:0] w0, w1;
    int n0;
    void'($urandom(32'd20240607));

    // directed: all pass, with a request poked during the power-up run
    set_cfg(0, 0);
    run_powerup(1, 1);

    // R6 zeroization gating
    zeroize_req = 1;
    @(negedge clk);
    chk(out_en == 0, "R6 zeroize blocks", out_en, 0);
    repeat (5) @(negedge clk);
    chk(out_en == 0, "R6 zeroize held", out_en, 0);
    zeroize_req = 0;
    @(negedge clk);
    chk(out_en == 1, "R6 zeroize release", out_en, 1);

    // R7 on-demand pass
    n0 = log_n;
    pulse_req();
    @(negedge clk);
    chk(out_en == 0, "R7 out low during run", out_en, 0);
    rd(0, w0);
    chk(w0 == 8'h08, "R7 busy bit", w0, 8);
    repeat (SETTLE) @(negedge clk);
    chk(log_n == n0 + NA, "R7 rerun count", log_n, n0 + NA);
    for (int j = 0; j < NA; j++)
      chk(log_id[n0 + j] == 8 + j, "R7 rerun order", log_id[n0 + j], 8 + j);
    rd(0, w0);
    chk(w0 == 8'h01 && out_en == 1, "R7 back to ready", {w0, out_en}, 9'h003);

    // R7 on-demand fail
    apass[2] = 0;
    pulse_req();
    repeat (SETTLE) @(negedge clk);
    rd(0, w0);
    rd(1, w1);
    chk(w0 == 8'h04, "R7 on-demand error", w0, 4);
    chk(w1 == 8'h04, "R7 fail bit", w1, 4);
    chk(link_en == 1 && out_en == 0, "R7 link kept, out blocked", {link_en, out_en}, 2'b10);
    check_sticky();

    // directed corners
    set_cfg(1, 0); run_powerup(1, 0); check_sticky();
    set_cfg(2, 2); run_powerup(0, 0); check_sticky();
    set_cfg(3, 0); run_powerup(0, 0); check_sticky();
    set_cfg(4, 3); run_powerup(0, 0); check_sticky();

    // random mix
    for (int t = 0; t < 8; t++) begin
      set_cfg(int'($urandom_range(0, 4)), int'($urandom_range(0, 7)));
      run_powerup(0, t[0]);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule